// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit

This unit takes two signed two's-complement operands and, on each cycle where `in_valid` is high, computes one of four clamped operations (add, subtract, add of a doubled second operand, subtract of a doubled second operand) or a plain wrapping add. A clamped result never wraps around. It is pinned to the largest positive or the most negative representable value. The result is registered, so it appears one clock after the request together with a one-cycle `out_valid` pulse.

A status word comes with the result. Its overflow bit reports signed overflow of the wrapping add. Its sticky bit records that some clamped operation has hit a limit since the last clear. A two-state machine holds the sticky bit. In state `STK_CLEAR` it moves to `STK_SET` on any saturation event (transition *saturate*). In `STK_SET` it returns to `STK_CLEAR` only when `sticky_clr` is high and no saturation event happens in the same cycle (transition *clear*). In every other case it stays where it is.

Top module: `satalu_top`

## Requirements
- R1: A request with `in_valid` high produces its `result` and `status` at the next rising edge, and `out_valid` is high for exactly that cycle. While `in_valid` is low, `out_valid` is low at the next edge and `result` keeps its value.
- R2: Op code 0 (clamped add) returns a+b when it fits. Positive overflow returns 0x7FFFFFFF and negative overflow returns 0x80000000.
- R3: Op code 1 (clamped subtract) returns a−b, clamped to the same two limits.
- R4: Op codes 2 and 3 first double b with clamping, then add the doubled value to a (code 2) or subtract it from a (code 3), clamping again. The sticky bit is set if either step clamps.
- R5: Op code 4 (wrapping add) returns (a+b) mod 2^32. Status bit 28 is set exactly when that add overflows as a signed value. Every other op code leaves bit 28 clear. The wrapping add never changes the sticky bit.
- R6: The sticky bit is status bit 27. It is set by any clamping event and stays set through later operations that do not clamp.
- R7: `sticky_clr` clears the sticky bit at the next edge. If a clamping event occurs in the same cycle, the bit ends up set.
- R8: After reset, `result` is 0, `out_valid` is 0 and every status bit is 0.
- R9: Op codes 5 to 7 return 0, clear bit 28 and do not touch the sticky bit. All status bits other than 27 and 28 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 add, 1 sub, 2 double-add, 3 double-sub, 4 wrap add) |
| a | input | 32 | First operand, signed |
| b | input | 32 | Second operand, signed |
| sticky_clr | input | 1 | Clears the sticky saturation bit |
| out_valid | output | 1 | Result valid pulse |
| result | output | 32 | Registered result |
| status | output | 32 | Bit 28 overflow of wrapping add, bit 27 sticky saturation |

## Verification
The properties assume that `in_valid`, `op` and `sticky_clr` are known, stable values at each rising edge once reset is released. The sticky-hold and sticky-clear properties depend only on whether a clamping event or a clear is present, so they make no assumption about operand values. The bench drives every input on the falling edge and returns `in_valid` and `sticky_clr` low between scenarios. Each clear is either issued alone or paired deliberately with a clamping request, so each transition of the sticky machine is reached on purpose.

// File: rtl/satalu_pkg.sv
package satalu_pkg;
    typedef enum logic [2:0] {
        OP_QADD  = 3'd0,
        OP_QSUB  = 3'd1,
        OP_QDADD = 3'd2,
        OP_QDSUB = 3'd3,
        OP_WADD  = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_SET   = 1'b1
    } stk_state_e;
endpackage

// File: rtl/sat_double.sv
module sat_double #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y,
    output logic             sat
);
    localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        sat = x[WIDTH-1] ^ x[WIDTH-2];
        if (sat) y = x[WIDTH-1] ? NEG_LIM : POS_LIM;
        else     y = {x[WIDTH-2:0], 1'b0};
    end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] y,
    output logic             sat
);
    localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH:0] ext_a, ext_b, ext_r;

    always_comb begin
        ext_a = {a[WIDTH-1], a};
        ext_b = {b[WIDTH-1], b};
        ext_r = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        sat   = ext_r[WIDTH] ^ ext_r[WIDTH-1];
        if (sat) y = ext_r[WIDTH] ? NEG_LIM : POS_LIM;
        else     y = ext_r[WIDTH-1:0];
    end
endmodule

// File: rtl/wrap_add.sv
module wrap_add #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             ovf
);
    always_comb begin
        y   = a + b;
        ovf = (a[WIDTH-1] == b[WIDTH-1]) && (y[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/satalu_top.sv
module satalu_top
    import satalu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int STICKY_POS = 27,
    parameter int OVF_POS    = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sticky_clr,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic [WIDTH-1:0] status
);
    op_e              op_e_w;
    logic [WIDTH-1:0] b_dbl, b_eff, as_y, wr_y;
    logic             dbl_sat, as_sat, wr_ovf, use_dbl, do_sub;
    logic [WIDTH-1:0] res_d;
    logic             ovf_d, sat_evt;
    logic             ovf_q;
    stk_state_e       stk_q, stk_d;

    assign op_e_w = op_e'(op);

    sat_double #(.WIDTH(WIDTH)) i_dbl (
        .x(b), .y(b_dbl), .sat(dbl_sat)
    );

    sat_addsub #(.WIDTH(WIDTH)) i_as (
        .a(a), .b(b_eff), .sub(do_sub), .y(as_y), .sat(as_sat)
    );

    wrap_add #(.WIDTH(WIDTH)) i_wr (
        .a(a), .b(b), .y(wr_y), .ovf(wr_ovf)
    );

    // operation decode
    always_comb begin
        use_dbl = 1'b0;
        do_sub  = 1'b0;
        res_d   = '0;
        ovf_d   = 1'b0;
        sat_evt = 1'b0;
        unique case (op_e_w)
            OP_QADD: begin
                res_d   = as_y;
                sat_evt = as_sat;
            end
            OP_QSUB: begin
                do_sub  = 1'b1;
                res_d   = as_y;
                sat_evt = as_sat;
            end
            OP_QDADD: begin
                use_dbl = 1'b1;
                res_d   = as_y;
                sat_evt = as_sat | dbl_sat;
            end
            OP_QDSUB: begin
                use_dbl = 1'b1;
                do_sub  = 1'b1;
                res_d   = as_y;
                sat_evt = as_sat | dbl_sat;
            end
            OP_WADD: begin
                res_d = wr_y;
                ovf_d = wr_ovf;
            end
            default: begin
                res_d = '0;
            end
        endcase
        b_eff = use_dbl ? b_dbl : b;
    end

    // result and overflow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf_q     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_d;
                ovf_q  <= ovf_d;
            end
        end
    end

    // sticky state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= STK_CLEAR;
        else        stk_q <= stk_d;
    end

    // sticky next state
    always_comb begin
        stk_d = stk_q;
        unique case (stk_q)
            STK_CLEAR: if (in_valid && sat_evt) stk_d = STK_SET;
            STK_SET:   if (sticky_clr && !(in_valid && sat_evt)) stk_d = STK_CLEAR;
            default:   stk_d = STK_CLEAR;
        endcase
    end

    // status word outputs
    always_comb begin
        status             = '0;
        status[STICKY_POS] = (stk_q == STK_SET);
        status[OVF_POS]    = ovf_q;
    end
endmodule

// File: rtl/satalu_chk.sv
module satalu_chk #(
    parameter int WIDTH      = 32,
    parameter int STICKY_POS = 27,
    parameter int OVF_POS    = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       op,
    input logic             sticky_clr,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic [WIDTH-1:0] status
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R1
    AST_OVF_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 3'd4) |=> !status[OVF_POS]); // R5
    AST_WRAP_KEEPS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4 && !sticky_clr) |=> $stable(status[STICKY_POS])); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STICKY_POS] && !sticky_clr) |=> status[STICKY_POS]); // R6
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_clr && !in_valid) |=> !status[STICKY_POS]); // R7
    AST_RSV_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 3'd5 && !sticky_clr) |=> (result == '0 && $stable(status[STICKY_POS]))); // R9
endmodule

bind satalu_top satalu_chk #(
    .WIDTH(WIDTH), .STICKY_POS(STICKY_POS), .OVF_POS(OVF_POS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .sticky_clr(sticky_clr), .out_valid(out_valid), .result(result), .status(status)
);

// File: tb/test_satalu_top.sv
module test_satalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        sticky_clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    satalu_top i_satalu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .sticky_clr(sticky_clr), .out_valid(out_valid), .result(result), .status(status)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one request on a falling edge, check after the next rising edge
    task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] x,
                          input logic [31:0] y, input logic clr,
                          input logic [31:0] exp_res, input logic [31:0] exp_stat);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y; sticky_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; sticky_clr = 1'b0;
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " result"}, result, exp_res);
        chk({req, " status"}, status, exp_stat);
    endtask

    task automatic clear_alone();
        @(negedge clk);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        chk("R7 clear alone", status & 32'h0800_0000, 32'd0);
    endtask

    localparam logic [31:0] Q = 32'h0800_0000;
    localparam logic [31:0] V = 32'h1000_0000;

    task automatic t_reset();
        chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R8 reset result", result, 32'd0);
        chk("R8 reset status", status, 32'd0);
    endtask

    task automatic t_latency();
        run_op("R1 add", 3'd0, 32'd1, 32'd2, 1'b0, 32'd3, 32'd0);
        @(negedge clk);
        chk("R1 valid drops", {31'd0, out_valid}, 32'd0);
        chk("R1 result holds", result, 32'd3);
    endtask

    task automatic t_add();
        run_op("R5 wrap add", 3'd4, 32'h7000_0000, 32'h7FFF_FFFF, 1'b0, 32'hEFFF_FFFF, V);
        run_op("R2 pos clamp", 3'd0, 32'h7000_0000, 32'h7FFF_FFFF, 1'b0, 32'h7FFF_FFFF, Q);
        clear_alone();
        run_op("R2 neg clamp", 3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'h8000_0000, Q);
        run_op("R6 sticky kept", 3'd0, 32'hFFFF_FFFE, 32'd5, 1'b0, 32'd3, Q);
        run_op("R5 wrap keeps sticky", 3'd4, 32'd10, 32'd20, 1'b0, 32'd30, Q);
        clear_alone();
    endtask

    task automatic t_sub();
        run_op("R3 sub", 3'd1, 32'd5, 32'd9, 1'b0, 32'hFFFF_FFFC, 32'd0);
        run_op("R3 neg clamp", 3'd1, 32'h8000_0000, 32'd1, 1'b0, 32'h8000_0000, Q);
        clear_alone();
        run_op("R3 pos clamp", 3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF, Q);
        clear_alone();
    endtask

    task automatic t_double();
        run_op("R4 dadd", 3'd2, 32'd5, 32'd3, 1'b0, 32'd11, 32'd0);
        run_op("R4 dsub", 3'd3, 32'd10, 32'd3, 1'b0, 32'd4, 32'd0);
        run_op("R4 double clamp", 3'd2, 32'd0, 32'h4000_0000, 1'b0, 32'h7FFF_FFFF, Q);
        clear_alone();
        // doubled value clamps to most negative, then subtract clamps too
        run_op("R4 dsub twice", 3'd3, 32'd0, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF, Q);
        clear_alone();
        // doubling clamps but final add brings value in range
        run_op("R4 double only", 3'd2, 32'hC000_0000, 32'h4000_0000, 1'b0, 32'h3FFF_FFFF, Q);
        clear_alone();
    endtask

    task automatic t_clear_race();
        run_op("R7 set", 3'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 32'h7FFF_FFFF, Q);
        run_op("R7 clear with clamp", 3'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 32'h7FFF_FFFF, Q);
        run_op("R7 clear with plain op", 3'd0, 32'd1, 32'd1, 1'b1, 32'd2, 32'd0);
    endtask

    task automatic t_reserved();
        run_op("R5 set V", 3'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'd0, V);
        run_op("R9 rsv5", 3'd5, 32'd7, 32'd8, 1'b0, 32'd0, 32'd0);
        run_op("R2 set Q", 3'd0, 32'h7FFF_FFFF, 32'd7, 1'b0, 32'h7FFF_FFFF, Q);
        run_op("R9 rsv7 keeps sticky", 3'd7, 32'd1, 32'd1, 1'b0, 32'd0, Q);
        clear_alone();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        t_add();
        t_sub();
        t_double();
        t_clear_race();
        t_reserved();
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule